// File: doc/BRIEF.md
# SMBus Indexed Register Target

This block is a two-wire serial bus target that owns a bank of 8-bit control registers. It serves the rest of the chip through a parallel register bus. A host reaches the registers with indexed block transfers.

A write carries a starting register offset, then a byte count N, then N data bytes. A read first sets the offset with a write-addressed header, then issues a repeated start with the read address. The target answers with a byte count, followed by register contents from the offset onward. A single-byte access is a block access whose count is one.

SCL and SDA come in as plain inputs. SDA is driven through an active-high pull-low enable, so the pad stays open-drain. Both lines pass through a synchronizer and glitch filter before the protocol engine sees them. Some register fields are read-only views of chip inputs: frequency-select straps latched at power-up, and the vendor and revision identifiers.

Top module: `smb_regbank`

## Requirements
- R1: The 7-bit target address is 0x69, so address byte D2h (write) and D3h (read) are acknowledged. Any other address byte is not acknowledged, and the target ignores the bus until the next start condition.
- R2: In a write, the offset byte, a count byte N (1 to 255) and N data bytes are each acknowledged. Data byte k is written to register offset+k, so a single-byte write is the case N = 1.
- R3: A count byte of 00h is not acknowledged, the transfer is abandoned and no register changes.
- R4: Data bytes after the N-th byte of a write are not acknowledged and are not written.
- R5: After D2h, offset, repeated start and D3h, the target sends a count byte and then registers offset, offset+1, and so on. It sends one more byte for each master ACK. A master NACK ends the transfer and the target releases SDA.
- R6: The count byte returned on reads is 8 after reset. Each acknowledged nonzero write count N replaces it with N.
- R7: A stop condition at any point returns the target to idle with SDA released. Bytes already accepted stay written, and the next transfer works normally.
- R8: Reset values are: register 0 = FFh, register 1 = FCh, register 2 = F1h, and every other stored register 00h (including register 8, whose bit 1 enables divider programming). The parallel bus `regs_o` shows register i in bits [8i+7:8i].
- R9: Register 7 reads as {rev_id_i, vendor_id_i} (revision in bits 7:4). Register 6 bits 2:0 read as strap_i. Reserved bits (register 1 bit 1, register 2 bits 3:1) read 0. Writes to any of these bits are ignored.
- R10: The offset is 8 bits wide and wraps from FFh to 00h. Offsets at or above NREG read as 00h and ignore writes.
- R11: A pulse on SCL or SDA shorter than FILT clock cycles has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock from the pad |
| sda_i | input | 1 | Serial data as seen on the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | Latched frequency-select straps, read in register 6 bits 2:0 |
| vendor_id_i | input | 4 | Vendor identifier, read in register 7 bits 3:0 |
| rev_id_i | input | 4 | Revision identifier, read in register 7 bits 7:4 |
| regs_o | output | NREG*8 | Parallel view of all registers as read over the bus |

## Verification
The bench builds the block with NREG = 12 and FILT = 2, keeping the default address and read count. With only 12 registers, random offsets often land past the end of the bank, and the out-of-range and FFh-to-00h wrap cases can be reached with short transfers. A filter length of 2 means a one-cycle pulse on either line must be rejected: a single-cycle SCL spike during a low phase, or an SDA flip while SCL is high, would otherwise shift an extra bit or fake a start or stop.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RXACK,
    PH_TX,
    PH_TXACK
  } phase_t;

  typedef enum logic [1:0] {
    RL_ADDR,
    RL_OFFS,
    RL_CNT,
    RL_DATA
  } role_t;

  // Reset contents per register index (R8)
  function automatic logic [7:0] reg_rst(input int idx);
    case (idx)
      0:       return 8'hFF;
      1:       return 8'hFC;
      2:       return 8'hF1;
      default: return 8'h00;
    endcase
  endfunction

  // Bits a bus write may change; 0 = read-only or reserved (R9)
  function automatic logic [7:0] reg_wmask(input int idx);
    case (idx)
      1:       return 8'hFD;
      2:       return 8'hF1;
      6:       return 8'hF8;
      7:       return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/smb_pin_filter.sv
module smb_pin_filter #(
  parameter int FILT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic pin_o
);
  localparam int CW = $clog2(FILT + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      pin_o  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      if (sync_q[1] == pin_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT - 1)) begin
        pin_o <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R11: the filtered level only moves toward a differing synchronized level
  assert_filter_follows_R11: assert property (@(posedge clk) disable iff (rst)
    (pin_o != $past(pin_o)) |-> ($past(sync_q[1]) != $past(pin_o)));

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_pkg::*;
#(
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [7:0]      wr_idx,
  input  logic [7:0]      wr_data,
  input  logic [7:0]      rd_idx,
  input  logic [2:0]      strap_i,
  input  logic [3:0]      vendor_id_i,
  input  logic [3:0]      rev_id_i,
  output logic [7:0]      rd_data,
  output logic [NREG*8-1:0] regs_o
);

  logic [7:0] mem_q [NREG];
  logic [7:0] view  [NREG];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)
        mem_q[i] <= reg_rst(i);
      else if (wr_en && wr_idx == 8'(i))
        mem_q[i] <= (wr_data & reg_wmask(i)) | (mem_q[i] & ~reg_wmask(i));
    end
  end

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      logic [7:0] ro;
      case (i)
        6:       ro = {5'b0, strap_i};
        7:       ro = {rev_id_i, vendor_id_i};
        default: ro = 8'h00;
      endcase
      view[i] = (mem_q[i] & reg_wmask(i)) | (ro & ~reg_wmask(i));
    end
  end

  // R10: offsets past the bank read as zero
  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == 8'(i)) rd_data = view[i];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] MSK = reg_wmask(g);
    assign regs_o[g*8 +: 8] = view[g];

    // R9: protected bits keep their value across a write to this register
    assert_protected_bits_R9: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_idx == 8'(g)) |=> ((mem_q[g] & ~MSK) == ($past(mem_q[g]) & ~MSK)));
  end

endmodule

// File: rtl/smb_link_ctrl.sv
module smb_link_ctrl
  import smb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         DEF_COUNT = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl,
  input  logic       sda,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_idx,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       sda_oe
);

  phase_t     ph_q;
  role_t      role_q;
  logic       scl_d, sda_d;
  logic [3:0] bit_q;
  logic [7:0] sh_q, tx_q, ptr_q, left_q, rcnt_q;
  logic       rd_dir_q, mack_q;
  logic       accept;

  wire start_w = scl && scl_d && sda_d && !sda;
  wire stop_w  = scl && scl_d && !sda_d && sda;
  wire rise_w  = scl && !scl_d;
  wire fall_w  = !scl && scl_d;

  assign rd_idx = ptr_q;

  always_comb begin
    case (role_q)
      RL_ADDR: accept = (sh_q[7:1] == DEV_ADDR);
      RL_OFFS: accept = 1'b1;
      RL_CNT:  accept = (sh_q != 8'h00);
      default: accept = (left_q != 8'h00);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_IDLE;
      role_q   <= RL_ADDR;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
      bit_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      ptr_q    <= '0;
      left_q   <= '0;
      rcnt_q   <= 8'(DEF_COUNT);
      rd_dir_q <= 1'b0;
      mack_q   <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      scl_d <= scl;
      sda_d <= sda;
      wr_en <= 1'b0;
      if (start_w) begin
        ph_q   <= PH_RX;
        role_q <= RL_ADDR;
        bit_q  <= '0;
        sda_oe <= 1'b0;
      end else if (stop_w) begin
        ph_q   <= PH_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (ph_q)
          PH_RX: begin
            if (rise_w) begin
              sh_q  <= {sh_q[6:0], sda};
              bit_q <= bit_q + 1'b1;
            end else if (fall_w && bit_q == 4'd8) begin
              if (!accept) begin
                ph_q <= PH_IDLE;
              end else begin
                sda_oe <= 1'b1;
                ph_q   <= PH_RXACK;
                case (role_q)
                  RL_ADDR: begin rd_dir_q <= sh_q[0]; role_q <= RL_OFFS; end
                  RL_OFFS: begin ptr_q <= sh_q; role_q <= RL_CNT; end
                  RL_CNT:  begin left_q <= sh_q; rcnt_q <= sh_q; role_q <= RL_DATA; end
                  default: begin
                    wr_en   <= 1'b1;
                    wr_idx  <= ptr_q;
                    wr_data <= sh_q;
                    ptr_q   <= ptr_q + 8'd1;
                    left_q  <= left_q - 8'd1;
                  end
                endcase
              end
            end
          end
          PH_RXACK: begin
            if (fall_w) begin
              bit_q <= '0;
              if (rd_dir_q) begin
                tx_q   <= rcnt_q;
                sda_oe <= ~rcnt_q[7];
                ph_q   <= PH_TX;
              end else begin
                sda_oe <= 1'b0;
                ph_q   <= PH_RX;
              end
            end
          end
          PH_TX: begin
            if (rise_w) begin
              bit_q <= bit_q + 1'b1;
            end else if (fall_w) begin
              if (bit_q == 4'd8) begin
                sda_oe <= 1'b0;
                ph_q   <= PH_TXACK;
              end else begin
                sda_oe <= ~tx_q[3'(4'd7 - bit_q)];
              end
            end
          end
          PH_TXACK: begin
            if (rise_w) begin
              mack_q <= ~sda;
            end else if (fall_w) begin
              if (mack_q) begin
                tx_q   <= rd_data;
                sda_oe <= ~rd_data[7];
                ptr_q  <= ptr_q + 8'd1;
                bit_q  <= '0;
                ph_q   <= PH_TX;
              end else begin
                ph_q <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R7: an idle target never holds SDA low
  assert_idle_released_R7: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_IDLE) |-> !sda_oe);

  // R7: a stop always leaves the target idle and released
  assert_stop_release_R7: assert property (@(posedge clk) disable iff (rst)
    stop_w |=> (!sda_oe && ph_q == PH_IDLE));

  // R1: SDA is only pulled low while SCL is low, so no false start or stop
  assert_drive_on_low_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(scl));

  // R4: a register write only follows a byte that still fit the count
  assert_write_in_count_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(left_q) != 8'h00));

  // R6: the read count is never zero
  assert_rcnt_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    rcnt_q != 8'h00);

  // R2: the bit counter never passes a full byte
  assert_bitcnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    bit_q <= 4'd8);

endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
  parameter int         NREG      = 32,
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         FILT      = 3,
  parameter int         DEF_COUNT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        strap_i,
  input  logic [3:0]        vendor_id_i,
  input  logic [3:0]        rev_id_i,
  output logic [NREG*8-1:0] regs_o
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] raw_w, flt_w;
  logic       wr_en;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data;

  assign raw_w = {sda_i, scl_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    smb_pin_filter #(.FILT(FILT)) i_filt (
      .clk   (clk),
      .rst   (rst),
      .pin_i (raw_w[g]),
      .pin_o (flt_w[g])
    );
  end

  smb_link_ctrl #(.DEV_ADDR(DEV_ADDR), .DEF_COUNT(DEF_COUNT)) i_link (
    .clk     (clk),
    .rst     (rst),
    .scl     (flt_w[0]),
    .sda     (flt_w[1]),
    .rd_data (rd_data),
    .rd_idx  (rd_idx),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .sda_oe  (sda_oe_o)
  );

  smb_reg_bank #(.NREG(NREG)) i_bank (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .rd_idx      (rd_idx),
    .strap_i     (strap_i),
    .vendor_id_i (vendor_id_i),
    .rev_id_i    (rev_id_i),
    .rd_data     (rd_data),
    .regs_o      (regs_o)
  );

endmodule

// File: tb/test_smb_regbank.sv
module test_smb_regbank;
  localparam int NREG = 12;
  localparam int FILT = 2;
  localparam int Q    = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [3:0] VEND  = 4'h5;
  localparam logic [3:0] REV   = 4'hA;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs;
  wire  line = sda_m & ~sda_oe;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] mdl [NREG];
  logic [7:0] wbuf [8];
  logic [7:0] rcnt;

  always #10 clk = ~clk;

  smb_regbank #(.NREG(NREG), .FILT(FILT)) i_smb_regbank (
    .clk (clk), .rst (rst), .scl_i (scl_m), .sda_i (line), .sda_oe_o (sda_oe),
    .strap_i (STRAP), .vendor_id_i (VEND), .rev_id_i (REV), .regs_o (regs)
  );

  function automatic logic [7:0] b_rst(input int i);
    if (i == 0) return 8'hFF;
    if (i == 1) return 8'hFC;
    if (i == 2) return 8'hF1;
    return 8'h00;
  endfunction

  function automatic logic [7:0] b_msk(input int i);
    if (i == 7) return 8'h00;
    if (i == 6) return 8'hF8;
    if (i == 2) return 8'hF1;
    if (i == 1) return 8'hFD;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] exp_rd(input int off);
    if (off >= NREG) return 8'h00;
    if (off == 7) return {REV, VEND};
    if (off == 6) return {mdl[6][7:3], STRAP};
    return mdl[off];
  endfunction

  task automatic mdl_wr(input int off, input logic [7:0] d);
    if (off < NREG) mdl[off] = (d & b_msk(off)) | (mdl[off] & ~b_msk(off));
  endtask

  task automatic chk(input string tag, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send(input logic [7:0] b, input logic gl, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      if (gl) begin
        @(negedge clk) scl_m = 1'b1;
        @(negedge clk) scl_m = 1'b0;
      end
      q(); scl_m = 1'b1; q();
      if (gl) begin
        sda_m = ~b[i];
        @(negedge clk) sda_m = b[i];
      end
      q(); scl_m = 1'b0; q();
    end
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = ~line; q(); scl_m = 1'b0; q();
  endtask

  task automatic recv(output logic [7:0] b, input logic give_ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl_m = 1'b1; q(); b[i] = line; q(); scl_m = 1'b0;
    end
    q(); sda_m = ~give_ack; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q(); sda_m = 1'b1;
  endtask

  task automatic xfer_write(input int off, input int n, input int extra, input logic gl);
    logic a;
    bus_start();
    send(8'hD2, 1'b0, a); chk("R1", a, 1, "write address ack");
    send(8'(off), 1'b0, a); chk("R2", a, 1, "offset ack");
    send(8'(n), 1'b0, a);
    if (n == 0) begin
      chk("R3", a, 0, "zero count nack");
      bus_stop();
      return;
    end
    chk("R2", a, 1, "count ack");
    rcnt = 8'(n);
    for (int i = 0; i < n; i++) begin
      send(wbuf[i], gl, a);
      chk(gl ? "R11" : "R2", a, 1, "data ack");
      mdl_wr((off + i) % 256, wbuf[i]);
    end
    for (int i = 0; i < extra; i++) begin
      send(8'h5A, 1'b0, a); chk("R4", a, 0, "excess byte nack");
    end
    bus_stop();
  endtask

  task automatic xfer_read(input int off, input int n, input string tag);
    logic a;
    logic [7:0] b;
    bus_start();
    send(8'hD2, 1'b0, a); chk("R1", a, 1, "write address ack");
    send(8'(off), 1'b0, a); chk("R5", a, 1, "read offset ack");
    bus_start();
    send(8'hD3, 1'b0, a); chk("R1", a, 1, "read address ack");
    recv(b, 1'b1); chk("R6", b, rcnt, "count byte");
    for (int i = 0; i < n; i++) begin
      recv(b, i != n - 1);
      chk(tag, b, exp_rd((off + i) % 256), "read data");
    end
    bus_stop();
    q();
    chk("R7", sda_oe, 0, "SDA released after stop");
  endtask

  task automatic check_bus(input string tag);
    for (int i = 0; i < NREG; i++)
      chk((i == 6 || i == 7) ? "R9" : tag, regs[i*8 +: 8], exp_rd(i), "register bus");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic a;
    int unsigned seed;
    seed = $urandom(32'd4711);
    for (int i = 0; i < NREG; i++) mdl[i] = b_rst(i);
    rcnt = 8'd8;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R8 reset state on the bus, SDA released
    chk("R8", sda_oe, 0, "SDA idle after reset");
    check_bus("R8");

    // R6 default count, R5 read from reset state
    xfer_read(0, 3, "R5");

    // R1 wrong address: no ack, rest ignored
    bus_start();
    send(8'hA4, 1'b0, a); chk("R1", a, 0, "foreign address nack");
    send(8'h03, 1'b0, a); chk("R1", a, 0, "ignored after mismatch");
    send(8'h01, 1'b0, a); chk("R1", a, 0, "ignored after mismatch");
    send(8'h77, 1'b0, a); chk("R1", a, 0, "ignored after mismatch");
    bus_stop();
    check_bus("R1");

    // R2 single-byte write, then multi-byte
    wbuf[0] = 8'h3C;
    xfer_write(4, 1, 0, 1'b0);
    xfer_read(4, 1, "R2");
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    xfer_write(3, 3, 0, 1'b0);
    check_bus("R2");

    // R3 zero count
    xfer_write(3, 0, 0, 1'b0);
    check_bus("R3");
    xfer_read(3, 2, "R3");

    // R4 excess bytes
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2;
    xfer_write(9, 2, 2, 1'b0);
    check_bus("R4");

    // R9 protected bits
    wbuf[0] = 8'hFF; wbuf[1] = 8'hFF;
    xfer_write(1, 2, 0, 1'b0);
    xfer_write(6, 2, 0, 1'b0);
    xfer_read(1, 2, "R9");
    xfer_read(6, 2, "R9");
    check_bus("R9");

    // R10 out of range and wrap
    wbuf[0] = 8'h99;
    xfer_write(NREG, 1, 0, 1'b0);
    wbuf[0] = 8'hE1; wbuf[1] = 8'h4B;
    xfer_write(255, 2, 0, 1'b0);
    xfer_read(254, 3, "R10");
    check_bus("R10");

    // R7 stop in the middle of a write
    bus_start();
    send(8'hD2, 1'b0, a); send(8'h05, 1'b0, a); send(8'h03, 1'b0, a);
    rcnt = 8'd3;
    send(8'h6D, 1'b0, a); chk("R7", a, 1, "first data ack before stop");
    mdl_wr(5, 8'h6D);
    bus_stop();
    q();
    chk("R7", sda_oe, 0, "SDA released after early stop");
    check_bus("R7");
    xfer_read(5, 2, "R7");

    // R11 glitches on both lines during data bits
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A;
    xfer_write(8, 2, 0, 1'b1);
    check_bus("R11");

    // random mix
    for (int it = 0; it < 14; it++) begin
      int off;
      int n;
      off = int'($urandom_range(NREG + 1, 0));
      n   = int'($urandom_range(4, 1));
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      xfer_write(off, n, 0, 1'b0);
      xfer_read(off, n, "R5");
    end
    check_bus("R2");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule